// File: doc/BRIEF.md
# Secant-Iteration Amplitude Predistorter

This block predistorts the magnitude of a transmit sample so that a memoryless cubic amplifier model, N(z) = a1·z + a3·z³, returns the sample scaled by a target gain g. It finds the root of the residual T(z) = N(z) − g·u with three unrolled secant steps. A secant step replaces the derivative by the slope between the current point and the previous one. The first two points are fixed: the earlier one is zero and the later one is the input itself. Because N(0) is zero, the residual at the earlier point is just −g·u, so no model evaluation is needed for it. Each stage passes its point and its residual forward, and the next stage uses them as its own previous point. As a result each stage evaluates the model only once.

The pipeline accepts one sample per clock. Each sample carries its own valid flag, and all arithmetic is unsigned-magnitude fixed point with separate sign handling. The three coefficients (linear gain a1, cubic coefficient a3 with its own sign bit, and target gain g) are captured into registers. Each secant stage contains its own reciprocal unit. The divide is therefore a reciprocal followed by multiplications.

Top module: `pdist_secant_top`

## Requirements
- R1: While reset is high and on the cycle after it, out_valid is 0 and out_z is 0.
- R2: A sample presented with in_valid high is captured on the next rising edge. Its result appears with out_valid high exactly 7 rising edges after capture, i.e. a fixed latency of 7 cycles. Samples may arrive back to back, and order is kept.
- R3: The coefficient inputs are registered, and a sample uses the values presented at least one cycle before it. The target product is gu = min(floor(cfg_gain·u / 2^14), 2^17−1). Seeds are z0 = u, z−1 = 0 and T(z−1) = −gu.
- R4: The model is evaluated as follows. z2 = floor(z·z/2^16) and z3 = floor(z2·z/2^16). p1 = floor(cfg_lin·z/2^14) and p3 = floor(cfg_cub·z3/2^14). N = p1 − p3 when cfg_cub_neg is 1, and p1 + p3 otherwise. N is then clamped to [−2^20, 2^20−1], and T = N − gu.
- R5: Each stage forms dz = z − zp, dT = T(z) − T(zp) and r = floor(2^32/|dT|). The step magnitude is m = floor(|dz|·|T(z)|·r / 2^32). The stage produces z − m when dz·T·dT is positive and z + m when it is negative.
- R6: If dT is zero, the stage passes z through unchanged. In particular, an input of 0 always yields 0.
- R7: Each new point is clamped to the range 0 to 2^17−1.
- R8: While out_valid is low, out_z holds the last result.
- R9: The output is the point produced by the third secant stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_u | input | 17 | Input magnitude, 16 fraction bits |
| cfg_lin | input | 17 | Linear model coefficient, 14 fraction bits |
| cfg_cub | input | 17 | Cubic coefficient magnitude, 14 fraction bits |
| cfg_cub_neg | input | 1 | Sign of the cubic coefficient (1 = negative) |
| cfg_gain | input | 17 | Target gain, 14 fraction bits |
| out_valid | output | 1 | Result strobe |
| out_z | output | 17 | Predistorted magnitude, 16 fraction bits |

## Verification
The bench builds the block with its default of three stages. With three stages, a result differs from the one- and two-stage iterates wherever the cubic term matters, so the fixed 7-cycle latency and the third-stage value are both visible. Compressive and expansive coefficient sets, an exactly linear model, and a very low linear gain are used. Together they reach the zero-denominator bypass, saturation of the gain product, and clamping of new points at the top of the 17-bit range.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned PD_W    = 17;  // magnitude width
  localparam int unsigned PD_FRAC = 16;  // fraction bits of magnitudes
  localparam int unsigned PD_PF   = 14;  // fraction bits of coefficients
  localparam int unsigned PD_NW   = 21;  // clamp width of model output
  localparam int unsigned PD_TW   = 22;  // residual width (signed)
  localparam int unsigned PD_DW   = 23;  // residual difference width (signed)
  localparam int unsigned PD_RW   = 32;  // reciprocal fraction bits

  typedef struct packed {
    logic                     vld;
    logic [PD_W-1:0]          z;
    logic [PD_W-1:0]          zp;
    logic [PD_W-1:0]          gu;
    logic signed [PD_TW-1:0]  tp;
  } pd_carry_t;
endpackage

// File: rtl/pd_model_eval.sv
module pd_model_eval
  import pd_pkg::*;
(
  input  logic [PD_W-1:0]         z,
  input  logic [PD_W-1:0]         coef_lin,
  input  logic [PD_W-1:0]         coef_cub,
  input  logic                    coef_cub_neg,
  input  logic [PD_W-1:0]         gu,
  output logic signed [PD_TW-1:0] resid
);
  localparam int unsigned W2  = 2 * PD_W;
  localparam int unsigned Q2W = W2 - PD_FRAC;
  localparam int unsigned W3  = Q2W + PD_W;
  localparam int unsigned Q3W = W3 - PD_FRAC;
  localparam int unsigned P3F = PD_W + Q3W;
  localparam int unsigned SW  = 24;
  localparam logic signed [SW-1:0] NMAX = SW'((1 << (PD_NW - 1)) - 1);
  localparam logic signed [SW-1:0] NMIN = -NMAX - SW'(1);

  logic [W2-1:0]         zz;
  logic [W3-1:0]         zzz;
  logic [W2-1:0]         p1f;
  logic [P3F-1:0]        p3f;
  logic signed [SW-1:0]  a, b, nsum, nsat;

  always_comb begin
    zz   = W2'(z) * W2'(z);
    zzz  = W3'(zz[W2-1:PD_FRAC]) * W3'(z);
    p1f  = W2'(coef_lin) * W2'(z);
    p3f  = P3F'(coef_cub) * P3F'(zzz[W3-1:PD_FRAC]);
    a    = signed'(SW'(p1f[W2-1:PD_PF]));
    b    = signed'(SW'(p3f[P3F-1:PD_PF]));
    nsum = coef_cub_neg ? (a - b) : (a + b);
    if (nsum > NMAX)      nsat = NMAX;
    else if (nsum < NMIN) nsat = NMIN;
    else                  nsat = nsum;
    resid = PD_TW'(nsat) - signed'(PD_TW'(gu));
  end
endmodule

// File: rtl/pd_recip.sv
module pd_recip
  import pd_pkg::*;
(
  input  logic signed [PD_DW-1:0] den,
  output logic [PD_RW:0]          recip,
  output logic                    den_zero
);
  localparam int unsigned QW = PD_RW + 1;
  localparam logic [QW-1:0] ONE = QW'(1) << PD_RW;

  logic [PD_DW-1:0] mag;

  always_comb begin
    mag      = den[PD_DW-1] ? PD_DW'(-den) : PD_DW'(den);
    den_zero = (mag == '0);
    recip    = den_zero ? '0 : (ONE / QW'(mag));
  end
endmodule

// File: rtl/pd_secant_stage.sv
module pd_secant_stage
  import pd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PD_W-1:0] coef_lin,
  input  logic [PD_W-1:0] coef_cub,
  input  logic            coef_cub_neg,
  input  pd_carry_t       carry_i,
  output pd_carry_t       carry_o
);
  localparam int unsigned PW = (PD_W + 1) + PD_TW + (PD_RW + 1);
  localparam int unsigned MW = PW - PD_RW;
  localparam int unsigned ZW = MW + 2;
  localparam logic signed [ZW-1:0] ZMAX = signed'(ZW'({PD_W{1'b1}}));

  // Phase A: model evaluation at the current point
  logic signed [PD_TW-1:0] t_new;

  pd_model_eval u_eval (
    .z           (carry_i.z),
    .coef_lin    (coef_lin),
    .coef_cub    (coef_cub),
    .coef_cub_neg(coef_cub_neg),
    .gu          (carry_i.gu),
    .resid       (t_new)
  );

  logic                    a_vld;
  logic [PD_W-1:0]         a_z, a_zp, a_gu;
  logic signed [PD_TW-1:0] a_tp, a_ti;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
      a_z   <= '0;
      a_zp  <= '0;
      a_gu  <= '0;
      a_tp  <= '0;
      a_ti  <= '0;
    end else begin
      a_vld <= carry_i.vld;
      if (carry_i.vld) begin
        a_z  <= carry_i.z;
        a_zp <= carry_i.zp;
        a_gu <= carry_i.gu;
        a_tp <= carry_i.tp;
        a_ti <= t_new;
      end
    end
  end

  // Phase B: secant update
  logic signed [PD_W:0]    dz;
  logic signed [PD_DW-1:0] dt;
  logic [PD_RW:0]          recip;
  logic                    den_zero;

  assign dz = signed'({1'b0, a_z}) - signed'({1'b0, a_zp});
  assign dt = PD_DW'(a_ti) - PD_DW'(a_tp);

  pd_recip u_recip (
    .den     (dt),
    .recip   (recip),
    .den_zero(den_zero)
  );

  logic [PD_W:0]          adz;
  logic [PD_TW-1:0]       ati;
  logic [PW-1:0]          prod;
  logic signed [ZW-1:0]   base, mval, zw;
  logic                   grow;
  logic [PD_W-1:0]        z_next;

  always_comb begin
    adz  = dz[PD_W] ? (PD_W+1)'(-dz) : (PD_W+1)'(dz);
    ati  = a_ti[PD_TW-1] ? PD_TW'(-a_ti) : PD_TW'(a_ti);
    prod = PW'(adz) * PW'(ati) * PW'(recip);
    grow = dz[PD_W] ^ a_ti[PD_TW-1] ^ dt[PD_DW-1];
    base = signed'(ZW'(a_z));
    mval = signed'(ZW'(prod[PW-1:PD_RW]));
    zw   = grow ? (base + mval) : (base - mval);
    if (den_zero)        z_next = a_z;
    else if (zw < 0)     z_next = '0;
    else if (zw > ZMAX)  z_next = '1;
    else                 z_next = zw[PD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_o <= '0;
    end else begin
      carry_o.vld <= a_vld;
      if (a_vld) begin
        carry_o.z  <= z_next;
        carry_o.zp <= a_z;
        carry_o.gu <= a_gu;
        carry_o.tp <= a_ti;
      end
    end
  end
endmodule

// File: rtl/pdist_secant_top.sv
module pdist_secant_top
  import pd_pkg::*;
#(
  parameter int unsigned NSTAGES = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PD_W-1:0] in_u,
  input  logic [PD_W-1:0] cfg_lin,
  input  logic [PD_W-1:0] cfg_cub,
  input  logic            cfg_cub_neg,
  input  logic [PD_W-1:0] cfg_gain,
  output logic            out_valid,
  output logic [PD_W-1:0] out_z
);
  localparam int unsigned W2  = 2 * PD_W;
  localparam int unsigned GSW = W2 - PD_PF;

  logic [PD_W-1:0] lin_q, cub_q, gain_q;
  logic            cub_neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_q     <= '0;
      cub_q     <= '0;
      cub_neg_q <= 1'b0;
      gain_q    <= '0;
    end else begin
      lin_q     <= cfg_lin;
      cub_q     <= cfg_cub;
      cub_neg_q <= cfg_cub_neg;
      gain_q    <= cfg_gain;
    end
  end

  // Target product, formed once per sample
  logic [W2-1:0]   gprod;
  logic [GSW-1:0]  gsh;
  logic [PD_W-1:0] gu_sat;

  always_comb begin
    gprod  = W2'(gain_q) * W2'(in_u);
    gsh    = gprod[W2-1:PD_PF];
    gu_sat = (gsh > GSW'({PD_W{1'b1}})) ? '1 : gsh[PD_W-1:0];
  end

  pd_carry_t chain [NSTAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain[0] <= '0;
    end else begin
      chain[0].vld <= in_valid;
      if (in_valid) begin
        chain[0].z  <= in_u;
        chain[0].zp <= '0;
        chain[0].gu <= gu_sat;
        chain[0].tp <= -signed'(PD_TW'(gu_sat));
      end
    end
  end

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    pd_secant_stage u_stage (
      .clk         (clk),
      .rst         (rst),
      .coef_lin    (lin_q),
      .coef_cub    (cub_q),
      .coef_cub_neg(cub_neg_q),
      .carry_i     (chain[s]),
      .carry_o     (chain[s+1])
    );
  end

  assign out_valid = chain[NSTAGES].vld;
  assign out_z     = chain[NSTAGES].z;
endmodule

// File: rtl/pdist_secant_chk.sv
module pdist_secant_chk #(
  parameter int unsigned LAT = 7,
  parameter int unsigned W   = 17
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_u,
  input logic         out_valid,
  input logic [W-1:0] out_z
);
  logic [LAT-1:0] vsh, zsh;
  logic           rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      vsh <= '0;
      zsh <= '0;
    end else begin
      vsh <= {vsh[LAT-2:0], in_valid};
      zsh <= {zsh[LAT-2:0], in_valid && (in_u == '0)};
    end
  end

  // R1: outputs quiet after a reset edge
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_quiet: assert (!out_valid && out_z == '0)
        else $error("reset state violated");
    end
  end

  // R2: fixed latency of the valid flag
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[LAT-1]);

  // R2: results are never unknown
  a_r2_known_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_z));

  // R6: zero in gives zero out
  a_r6_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
    zsh[LAT-1] |-> out_z == '0);

  // R8: output holds while idle
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_z));
endmodule

bind pdist_secant_top pdist_secant_chk #(.LAT(1 + 2 * NSTAGES), .W(17)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_u     (in_u),
  .out_valid(out_valid),
  .out_z    (out_z)
);

// File: tb/test_pdist_secant_top.sv
module test_pdist_secant_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [16:0] in_u = '0;
  logic [16:0] cfg_lin = '0, cfg_cub = '0, cfg_gain = '0;
  logic        cfg_cub_neg = 1'b0;
  logic        out_valid;
  logic [16:0] out_z;

  always #2.5 clk = ~clk;

  pdist_secant_top i_pdist_secant_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_u(in_u),
    .cfg_lin(cfg_lin), .cfg_cub(cfg_cub), .cfg_cub_neg(cfg_cub_neg),
    .cfg_gain(cfg_gain), .out_valid(out_valid), .out_z(out_z)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  longint th1 = 0, th3 = 0, gg = 0;
  bit     tneg = 0;
  logic [16:0] exp_q [$];
  int          cyc_q [$];
  string       tag_q [$];
  logic [16:0] last_z = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // R4 residual of the cubic model
  function automatic longint resid(input longint z, input longint gu);
    longint z2, z3, p1, p3, n;
    z2 = (z * z) >> 16;
    z3 = (z2 * z) >> 16;
    p1 = (th1 * z) >> 14;
    p3 = (th3 * z3) >> 14;
    n  = tneg ? (p1 - p3) : (p1 + p3);
    if (n > 1048575) n = 1048575;
    if (n < -1048576) n = -1048576;
    return n - gu;
  endfunction

  // R3, R5, R6, R7, R9 reference iteration
  function automatic logic [16:0] model(input longint u);
    longint gu, z, zp, tp, ti, dz, dt, zn, rc, mag;
    logic [95:0] p;
    bit grow;
    gu = (gg * u) >> 14;
    if (gu > 131071) gu = 131071;
    z = u; zp = 0; tp = -gu;
    for (int s = 0; s < 3; s++) begin
      ti = resid(z, gu);
      dz = z - zp;
      dt = ti - tp;
      zn = z;
      if (dt != 0) begin
        rc   = (longint'(1) << 32) / absl(dt);
        p    = 96'(absl(dz)) * 96'(absl(ti)) * 96'(rc);
        mag  = longint'(p >> 32);
        grow = (dz < 0) ^ (ti < 0) ^ (dt < 0);
        zn   = grow ? (z + mag) : (z - mag);
        if (zn < 0) zn = 0;
        if (zn > 131071) zn = 131071;
      end
      zp = z; tp = ti; z = zn;
    end
    return z[16:0];
  endfunction

  // Result monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", out_z, -1);
        end else begin
          logic [16:0] e;
          int          c;
          string       t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          check(out_z == e, t, out_z, e);
          check(cyc == c + 7, "R2 latency", cyc - c, 7);
        end
        last_z = out_z;
      end else if (n_chk > 0) begin
        check(out_z == last_z, "R8 idle hold", out_z, last_z);
      end
    end
  end

  task automatic send(input logic [16:0] u, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_u     = u;
    exp_q.push_back(model(u));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_u     = $urandom();
    end
  endtask

  task automatic setp(input longint a1, input longint a3, input bit ng, input longint g);
    idle(10);
    th1 = a1; th3 = a3; tneg = ng; gg = g;
    cfg_lin = a1[16:0]; cfg_cub = a3[16:0]; cfg_cub_neg = ng; cfg_gain = g[16:0];
    idle(2);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_z == '0, "R1 reset data", out_z, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_z == '0, "R1 after reset", out_z, 0);

    // Exactly linear model: one step lands on u, later steps hold
    setp(16384, 0, 0, 16384);
    send(17'd0, "R6 zero input");
    send(17'd40000, "R5 linear");
    send(17'd65536, "R5 linear");
    send(17'd131071, "R5 linear");
    idle(1);

    // Compressive amplifier
    setp(16384, 5000, 1, 14000);
    send(17'd0, "R6 zero input");
    send(17'd1, "R4 compressive small");
    send(17'd50000, "R4 compressive");
    send(17'd90000, "R9 compressive three steps");
    idle(3);
    send(17'd120000, "R4 compressive");

    // Expansive amplifier with a saturated gain product
    setp(16384, 3000, 0, 30000);
    send(17'd120000, "R3 gain product clamp");
    send(17'd30000, "R3 expansive");

    // Very low linear gain forces the upper clamp
    setp(1000, 0, 0, 16384);
    send(17'd100000, "R7 upper clamp");
    send(17'd60000, "R7 upper clamp");

    // Random coefficient sets and traffic
    for (int k = 0; k < 6; k++) begin
      setp(12000 + ($urandom() % 8000), $urandom() % 8000, 1'($urandom() % 2), 12000 + ($urandom() % 8000));
      for (int j = 0; j < 60; j++) begin
        if (($urandom() % 10) < 3) idle(1 + $urandom() % 3);
        case ($urandom() % 8)
          0:       send(17'd0, "R6 random zero");
          1:       send(17'd131071, "R7 random top");
          default: send(17'($urandom()), "R9 random");
        endcase
      end
    end
    idle(20);
    check(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule